// File: doc/BRIEF.md
# Block-Copy DMA Register Front End

This block is the software-facing front end of a DMA engine that copies whole fixed-size blocks between a device-side block store and host memory. Software programs a device block index and a host byte address through a plain synchronous register port. It then writes a count word. That write both starts the copy and chooses its direction. The engine then walks the blocks one at a time. For each block it raises a request toward a bus master, carrying the block index, the host address and the direction, and it holds the request until the master acknowledges it.

On each good acknowledge the engine moves to the next block. It adds one to the block index, adds one block of bytes to the host address and lowers the visible count by one. A status register shows whether the engine is busy and keeps a sticky error flag. All register data on the port is byte-reversed against the logical value, in both directions. The burst length of the master is 4 or 8 words of 32 bits, and one block is exactly one burst. Any other burst length stops elaboration.

Top module: `blkcopy_dma`

## Requirements
- R1: After reset every register reads zero and `req_o` is low.
- R2: Register data is byte-reversed on both writes and reads: bus bits 7:0 hold logical bits 31:24, bus bits 15:8 hold logical bits 23:16, and so on. A value written therefore reads back unchanged on the bus, while the logical value appears on the request outputs.
- R3: The register map, by `reg_addr_i`, is as follows. Address 0 is the block index. Address 1 is the host byte address. Address 2 is the count word: logical bit 31 is the direction (1 = host to device), bits 15:0 are the blocks remaining, and a read returns {direction, zeros, remaining}. Address 3 is the status: logical bit 0 is busy and bit 1 is error.
- R4: A count write with a nonzero low field, made while the engine is idle, error-free and holding a block-aligned host address, sets busy. `req_o` is then high from the next cycle. A count write of zero starts nothing.
- R5: While the request is up, `req_blk_o` and `req_haddr_o` show the current block index and host address, and `req_write_o` shows the direction bit.
- R6: Each good acknowledge adds 1 to the block index, adds BURST_WORDS*4 to the host address and subtracts 1 from the remaining count.
- R7: After the acknowledge of the last block, busy clears, the count reads zero and `req_o` is low in the next cycle.
- R8: An error acknowledge sets the sticky error flag, clears busy, keeps the remaining count and drops the request. While the flag is set, count writes are ignored. Writing logical bit 1 of the status register clears the flag.
- R9: Writes to the block, host address or count registers while busy have no effect.
- R10: A start attempt with a host address that is not a multiple of the block size sets the error flag and does not start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data (byte-reversed) |
| reg_rdata_o | output | 32 | Register read data (byte-reversed), combinational |
| req_o | output | 1 | Block burst request |
| req_write_o | output | 1 | Direction of request, 1 = host to device |
| req_blk_o | output | 32 | Device block index of request |
| req_haddr_o | output | 32 | Host byte address of request |
| ack_i | input | 1 | Request acknowledge |
| ack_err_i | input | 1 | Acknowledge carries an error |

## Verification
A wrong block index or host address step shows up on the request outputs one cycle after the acknowledge that caused it. A count that is decremented badly shows up either as a wrong readback or as a request that runs one block too long or stops one block short, and this is seen at the final acknowledge. A wrong busy or error state shows in the status readback and on `req_o` in the very next cycle. A bad byte lane shows up at once as a request field that does not match the swapped value written.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    RA_BLK   = 2'd0,
    RA_HADDR = 2'd1,
    RA_COUNT = 2'd2,
    RA_STAT  = 2'd3
  } reg_addr_e;

  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int DIR_BIT = 31;
endpackage

// File: rtl/blkcopy_bswap.sv
module blkcopy_bswap #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] d_i,
  output logic [BYTES*8-1:0] d_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign d_o[b*8 +: 8] = d_i[(BYTES-1-b)*8 +: 8];
  end
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int BLK_BYTES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_blk_i,
  input  logic             ld_haddr_i,
  input  logic             ld_cnt_i,
  input  logic             clr_err_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_wr_i,
  input  logic             dir_wr_i,
  input  logic             ack_i,
  input  logic             ack_err_i,
  output logic [REG_W-1:0] blk_o,
  output logic [REG_W-1:0] haddr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             busy_o,
  output logic             err_o
);
  localparam int BLK_SHIFT = $clog2(BLK_BYTES);

  logic [REG_W-1:0] blk_q, haddr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q, busy_q, err_q;
  logic             misaligned;

  assign misaligned = |haddr_q[BLK_SHIFT-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      haddr_q <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (busy_q) begin
      if (ack_i) begin
        if (ack_err_i) begin
          err_q  <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          blk_q   <= blk_q + 1'b1;
          haddr_q <= haddr_q + REG_W'(BLK_BYTES);
          cnt_q   <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) busy_q <= 1'b0;
        end
      end
    end else begin
      if (ld_blk_i)   blk_q   <= wdata_i;
      if (ld_haddr_i) haddr_q <= wdata_i;
      if (clr_err_i)  err_q   <= 1'b0;
      // start only from a clean idle state
      if (ld_cnt_i && !err_q && (cnt_wr_i != '0)) begin
        if (misaligned) begin
          err_q <= 1'b1;
        end else begin
          cnt_q  <= cnt_wr_i;
          dir_q  <= dir_wr_i;
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign blk_o   = blk_q;
  assign haddr_o = haddr_q;
  assign cnt_o   = cnt_q;
  assign dir_o   = dir_q;
  assign busy_o  = busy_q;
  assign err_o   = err_q;

  // R4: a transfer never starts with nothing to move
  a_r4_start_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (cnt_q != '0));
  // R6: host address advances by one block per good acknowledge
  a_r6_haddr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i && !ack_err_i) |=> (haddr_q == $past(haddr_q) + REG_W'(BLK_BYTES)));
  // R6: count drops by one per good acknowledge
  a_r6_cnt_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i && !ack_err_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R7: a clean finish leaves nothing outstanding
  a_r7_done_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_q) && !err_q) |-> (cnt_q == '0));
  // R8: error acknowledge stops the engine and flags it
  a_r8_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i && ack_err_i) |=> (!busy_o && err_o && $stable(cnt_q)));
  // R9: programming is frozen while a block waits
  a_r9_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i) |=> ($stable(blk_q) && $stable(haddr_q) && $stable(cnt_q) && $stable(dir_q)));
endmodule

// File: rtl/blkcopy_dma.sv
module blkcopy_dma
  import blkcopy_pkg::*;
#(
  parameter int BURST_WORDS = 8,
  parameter int CNT_W       = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  reg_addr_i,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        req_o,
  output logic        req_write_o,
  output logic [31:0] req_blk_o,
  output logic [31:0] req_haddr_o,
  input  logic        ack_i,
  input  logic        ack_err_i
);
  localparam int BLK_BYTES = BURST_WORDS * 4;

  if (BURST_WORDS != 4 && BURST_WORDS != 8) begin : g_bad_burst
    $error("blkcopy_dma: BURST_WORDS must be 4 or 8");
  end

  logic [REG_W-1:0] wdata_l, rdata_l;
  logic [REG_W-1:0] blk, haddr;
  logic [CNT_W-1:0] cnt;
  logic             dir, busy, err;
  logic             wr_blk, wr_haddr, wr_cnt, wr_stat;

  blkcopy_bswap #(.BYTES(REG_W/8)) u_swap_in  (.d_i(reg_wdata_i), .d_o(wdata_l));
  blkcopy_bswap #(.BYTES(REG_W/8)) u_swap_out (.d_i(rdata_l),     .d_o(reg_rdata_o));

  assign wr_blk   = reg_wr_i && (reg_addr_i == RA_BLK);
  assign wr_haddr = reg_wr_i && (reg_addr_i == RA_HADDR);
  assign wr_cnt   = reg_wr_i && (reg_addr_i == RA_COUNT);
  assign wr_stat  = reg_wr_i && (reg_addr_i == RA_STAT);

  blkcopy_engine #(.CNT_W(CNT_W), .BLK_BYTES(BLK_BYTES)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_blk_i   (wr_blk),
    .ld_haddr_i (wr_haddr),
    .ld_cnt_i   (wr_cnt),
    .clr_err_i  (wr_stat && wdata_l[ST_ERR]),
    .wdata_i    (wdata_l),
    .cnt_wr_i   (wdata_l[CNT_W-1:0]),
    .dir_wr_i   (wdata_l[DIR_BIT]),
    .ack_i      (ack_i),
    .ack_err_i  (ack_err_i),
    .blk_o      (blk),
    .haddr_o    (haddr),
    .cnt_o      (cnt),
    .dir_o      (dir),
    .busy_o     (busy),
    .err_o      (err)
  );

  always_comb begin
    rdata_l = '0;
    unique case (reg_addr_i)
      RA_BLK:   rdata_l = blk;
      RA_HADDR: rdata_l = haddr;
      RA_COUNT: rdata_l = {dir, {(REG_W-1-CNT_W){1'b0}}, cnt};
      RA_STAT:  begin
        rdata_l[ST_BUSY] = busy;
        rdata_l[ST_ERR]  = err;
      end
      default:  rdata_l = '0;
    endcase
  end

  assign req_o       = busy;
  assign req_write_o = dir;
  assign req_blk_o   = blk;
  assign req_haddr_o = haddr;

  // R8: busy and error are never both set
  a_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && err));
  // R9: a register write while a request is held leaves the request fields unchanged
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && reg_wr_i) |=> ($stable(req_blk_o) && $stable(req_haddr_o) && $stable(req_write_o)));
endmodule

// File: tb/sim_blkcopy_dma.sv
module sim_blkcopy_dma;
  localparam int STEP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req, req_write;
  logic [31:0] req_blk, req_haddr;
  logic        ack = 1'b0, ack_err = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  blkcopy_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_o(req),
    .req_write_o(req_write), .req_blk_o(req_blk), .req_haddr_o(req_haddr),
    .ack_i(ack), .ack_err_i(ack_err)
  );

  function automatic logic [31:0] sw(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // logical-value register write
  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = sw(v); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // returns logical value
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = sw(reg_rdata);
  endtask

  task automatic ack_one(input bit err);
    ack = 1'b1; ack_err = err;
    @(negedge clk);
    ack = 1'b0; ack_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk($sformatf("R1 reg%0d", a), v, 32'h0);
    end
    chk("R1 req", {31'b0, req}, 32'h0);
  endtask

  task automatic t_read_xfer();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_1000);
    rd(2'd0, v); chk("R2 blk readback", v, 32'h10);
    chk("R2 bus readback", reg_rdata, sw(32'h10));
    wr(2'd2, 32'h0000_0003);
    chk("R4 req up", {31'b0, req}, 32'h1);
    rd(2'd3, v); chk("R3 status busy", v, 32'h1);
    for (int k = 0; k < 3; k++) begin
      chk("R5 blk", req_blk, 32'h10 + k);
      chk("R5 haddr", req_haddr, 32'h1000 + k * STEP);
      chk("R5 dir", {31'b0, req_write}, 32'h0);
      rd(2'd2, v); chk("R6 remaining", v, 32'(3 - k));
      ack_one(1'b0);
    end
    chk("R7 req low", {31'b0, req}, 32'h0);
    rd(2'd2, v); chk("R7 count zero", v, 32'h0);
    rd(2'd3, v); chk("R7 status idle", v, 32'h0);
    rd(2'd0, v); chk("R6 blk after", v, 32'h13);
    rd(2'd1, v); chk("R6 haddr after", v, 32'h1000 + 3 * STEP);
  endtask

  task automatic t_write_dir();
    logic [31:0] v;
    wr(2'd0, 32'h0A0B_0C00);
    wr(2'd1, 32'h8000_0040);
    wr(2'd2, 32'h8000_0002);
    chk("R5 write dir", {31'b0, req_write}, 32'h1);
    chk("R2 blk lanes", req_blk, 32'h0A0B_0C00);
    chk("R2 haddr lanes", req_haddr, 32'h8000_0040);
    ack_one(1'b0);
    ack_one(1'b0);
    rd(2'd2, v); chk("R3 count dir readback", v, 32'h8000_0000);
    chk("R7 req low w", {31'b0, req}, 32'h0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(2'd0, 32'h20);
    wr(2'd1, 32'h2000);
    wr(2'd2, 32'h2);
    wr(2'd0, 32'h55);
    wr(2'd1, 32'h9900);
    wr(2'd2, 32'h8000_0007);
    chk("R9 blk kept", req_blk, 32'h20);
    chk("R9 haddr kept", req_haddr, 32'h2000);
    chk("R9 dir kept", {31'b0, req_write}, 32'h0);
    rd(2'd2, v); chk("R9 count kept", v, 32'h2);
    ack_one(1'b0);
    ack_one(1'b0);
    chk("R7 done", {31'b0, req}, 32'h0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    wr(2'd1, 32'h3000);
    wr(2'd2, 32'h0);
    chk("R4 zero no req", {31'b0, req}, 32'h0);
    rd(2'd3, v); chk("R4 zero status", v, 32'h0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    wr(2'd0, 32'h40);
    wr(2'd1, 32'h4000);
    wr(2'd2, 32'h4);
    ack_one(1'b0);
    ack_one(1'b1);
    chk("R8 req dropped", {31'b0, req}, 32'h0);
    rd(2'd3, v); chk("R8 status err", v, 32'h2);
    rd(2'd2, v); chk("R8 count kept", v, 32'h3);
    rd(2'd0, v); chk("R8 blk kept", v, 32'h41);
    wr(2'd2, 32'h5);
    chk("R8 start blocked", {31'b0, req}, 32'h0);
    rd(2'd2, v); chk("R8 count unchanged", v, 32'h3);
    wr(2'd3, 32'h2);
    rd(2'd3, v); chk("R8 err cleared", v, 32'h0);
  endtask

  task automatic t_misalign();
    logic [31:0] v;
    wr(2'd1, 32'h5004);
    wr(2'd2, 32'h1);
    chk("R10 no req", {31'b0, req}, 32'h0);
    rd(2'd3, v); chk("R10 err set", v, 32'h2);
    wr(2'd3, 32'h2);
    rd(2'd3, v); chk("R10 err cleared", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_xfer();
    t_write_dir();
    t_busy_ignore();
    t_zero();
    t_err();
    t_misalign();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule